// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block holds a 64-bit compare value for the supervisor-level timer and drives the supervisor timer-pending level. It compares that value against a free-running 64-bit time count, treating both as unsigned numbers. Software reaches the compare value through a CSR port that has a 12-bit address, 64-bit write data and combinational read data. A mode input chooses between full 64-bit access and split access, in which the value is reached as two 32-bit halves at two addresses.

The block runs the comparison every cycle and registers the result. The pending output is therefore a level that follows the time and compare value seen at the previous clock edge. An enable input from the machine-level environment configuration picks what drives that output. When the enable is set, the registered compare result drives it. When the enable is clear, the output is a plain copy of a software-writable pending bit supplied from machine level. Privilege checks, delegation and trap entry are handled elsewhere.

Top module: `stc_timer_cmp`

## Requirements
- R1: After reset the compare value is all ones (it reads as 64'hFFFF_FFFF_FFFF_FFFF), and the pending output is low while the time input is below that value.
- R2: With split_i low, address 0x14D writes all 64 bits of the compare value from csr_wdata_i and reads back all 64 bits on csr_rdata_o.
- R3: With split_i high, address 0x14D reaches compare bits 31:0 and address 0x15D reaches bits 63:32. A write takes csr_wdata_i[31:0] and leaves the other half unchanged. A read returns the half in csr_rdata_o[31:0] with bits 63:32 at zero.
- R4: Writes to any other address, and writes to 0x15D while split_i is low, leave the compare value unchanged. Reads at those addresses return zero.
- R5: With the enable set, the pending output is high exactly when time is greater than or equal to the compare value under unsigned comparison. This includes the equal case and values with bit 63 set.
- R6: The pending output reflects the time input and the compare value as they stood before the most recent rising clock edge. A compare write or a time change therefore shows on the output one cycle later.
- R7: With stce_i low, stip_o equals legacy_stip_i in the same cycle. Compare writes are still stored.
- R8: With stce_i high, legacy_stip_i has no effect on stip_o.
- R9: The comparison keeps running while the enable is low. Setting the enable again immediately shows the compare result of the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Free-running time count |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| split_i | input | 1 | 1: access in 32-bit halves, 0: full 64-bit access |
| stce_i | input | 1 | Enable for the compare-driven pending bit |
| legacy_stip_i | input | 1 | Software-written pending bit used while disabled |
| stip_o | output | 1 | Supervisor timer pending level |
| csr_rdata_o | output | 64 | CSR read data |

## Verification
The bench sets time exactly equal to the compare value, and also uses values where bit 63 differs. A comparator that is strict or signed would show the wrong level there. It checks the pending bit in the cycle right after a write or a time step, before the edge takes effect. This catches both a missing register stage and an extra one. In split mode it writes one half with junk in the upper write bits, and then reads the other half. This exposes a design that clobbers the neighbouring half or takes the wrong bits of the write data. It also toggles the legacy bit and the enable around a pending compare. This catches a mux with the wrong polarity, and a comparator that stalls while the enable is low.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam logic [11:0] ADDR_CMP_LO = 12'h14D;
  localparam logic [11:0] ADDR_CMP_HI = 12'h15D;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_FULL,
    SEL_LO,
    SEL_HI
  } cmp_sel_e;

  function automatic cmp_sel_e decode_sel(input logic [11:0] addr, input logic split);
    if (addr == ADDR_CMP_LO) return split ? SEL_LO : SEL_FULL;
    if (addr == ADDR_CMP_HI && split) return SEL_HI;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg
  import stc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [11:0]  addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         split_i,
  output logic [W-1:0] cmp_o,
  output logic [W-1:0] rdata_o
);
  localparam int HALF = W / 2;

  cmp_sel_e     sel;
  logic [W-1:0] cmp_q;

  assign sel = decode_sel(addr_i, split_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else if (we_i) begin
      unique case (sel)
        SEL_FULL: cmp_q <= wdata_i;
        SEL_LO:   cmp_q[HALF-1:0] <= wdata_i[HALF-1:0];
        SEL_HI:   cmp_q[W-1:HALF] <= wdata_i[HALF-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_FULL: rdata_o = cmp_q;
      SEL_LO:   rdata_o = {{(W-HALF){1'b0}}, cmp_q[HALF-1:0]};
      SEL_HI:   rdata_o = {{(W-HALF){1'b0}}, cmp_q[W-1:HALF]};
      default:  rdata_o = '0;
    endcase
  end

  assign cmp_o = cmp_q;

  a_r3_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && split_i && addr_i == ADDR_CMP_LO) |=> $stable(cmp_q[W-1:HALF]));
  a_r3_lo_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && split_i && addr_i == ADDR_CMP_HI) |=> $stable(cmp_q[HALF-1:0]));
  a_r4_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || (addr_i != ADDR_CMP_LO && addr_i != ADDR_CMP_HI) ||
     (addr_i == ADDR_CMP_HI && !split_i)) |=> $stable(cmp_q));
  a_r3_read_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_i |-> rdata_o[W-1:HALF] == '0);
endmodule

// File: rtl/stc_cmp_unit.sv
module stc_cmp_unit #(
  parameter int W       = 64,
  parameter int CHUNK_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] cmp_i,
  output logic         ge_o
);
  localparam int NCHUNK = W / CHUNK_W;

  logic [NCHUNK-1:0] chunk_gt;
  logic [NCHUNK-1:0] chunk_eq;
  logic              ge_d;
  logic              ge_q;

  // per-chunk compare keeps the carry chain short
  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    assign chunk_gt[i] = time_i[i*CHUNK_W +: CHUNK_W] >  cmp_i[i*CHUNK_W +: CHUNK_W];
    assign chunk_eq[i] = time_i[i*CHUNK_W +: CHUNK_W] == cmp_i[i*CHUNK_W +: CHUNK_W];
  end

  // most significant differing chunk decides; all equal means ge
  always_comb begin
    logic open;
    ge_d = 1'b1;
    open = 1'b1;
    for (int i = NCHUNK - 1; i >= 0; i--) begin
      if (open && !chunk_eq[i]) begin
        ge_d = chunk_gt[i];
        open = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ge_q <= 1'b0;
    else         ge_q <= ge_d;
  end

  assign ge_o = ge_q;

  a_r5_equal_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_i == cmp_i) |=> ge_q);
  a_r5_below_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_i[W-1] == 1'b0 && cmp_i[W-1] == 1'b1) |=> !ge_q);
endmodule

// File: rtl/stc_pend_sel.sv
module stc_pend_sel (
  input  logic ge_i,
  input  logic stce_i,
  input  logic legacy_i,
  output logic stip_o
);
  assign stip_o = stce_i ? ge_i : legacy_i;
endmodule

// File: rtl/stc_timer_cmp.sv
module stc_timer_cmp #(
  parameter int TIME_W  = 64,
  parameter int CHUNK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              csr_we_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [TIME_W-1:0] csr_wdata_i,
  input  logic              split_i,
  input  logic              stce_i,
  input  logic              legacy_stip_i,
  output logic              stip_o,
  output logic [TIME_W-1:0] csr_rdata_o
);
  logic [TIME_W-1:0] cmp_val;
  logic              ge;

  stc_cmp_reg #(.W(TIME_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .split_i (split_i),
    .cmp_o   (cmp_val),
    .rdata_o (csr_rdata_o)
  );

  stc_cmp_unit #(.W(TIME_W), .CHUNK_W(CHUNK_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_i (time_i),
    .cmp_i  (cmp_val),
    .ge_o   (ge)
  );

  stc_pend_sel u_sel (
    .ge_i     (ge),
    .stce_i   (stce_i),
    .legacy_i (legacy_stip_i),
    .stip_o   (stip_o)
  );

  // marks that one edge has passed since reset release, for $past use
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r6_one_cycle_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && stce_i) |-> stip_o == ($past(time_i) >= $past(cmp_val)));
  a_r7_write_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stce_i && csr_we_i && !split_i && csr_addr_i == 12'h14D) |=> cmp_val == $past(csr_wdata_i));
endmodule

// File: tb/stc_timer_cmp_test.sv
module stc_timer_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] t = '0;
  logic        we = 1'b0;
  logic [11:0] addr = 12'h14D;
  logic [63:0] wdata = '0;
  logic        split = 1'b0;
  logic        stce = 1'b1;
  logic        leg = 1'b0;
  logic        stip;
  logic [63:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] cmp_m = '1;
  logic        ge_m = 1'b0;

  always #2 clk = ~clk;

  stc_timer_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(t), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .split_i(split), .stce_i(stce), .legacy_stip_i(leg),
    .stip_o(stip), .csr_rdata_o(rdata)
  );

  function automatic logic [63:0] apply_wr(input logic [63:0] c, input logic [11:0] a,
                                           input logic s, input logic [63:0] d);
    logic [63:0] r = c;
    if (a == 12'h14D && !s) r = d;
    else if (a == 12'h14D && s) r[31:0] = d[31:0];
    else if (a == 12'h15D && s) r[63:32] = d[31:0];
    return r;
  endfunction

  function automatic logic [63:0] exp_rd(input logic [63:0] c, input logic [11:0] a, input logic s);
    if (a == 12'h14D) return s ? {32'h0, c[31:0]} : c;
    if (a == 12'h15D && s) return {32'h0, c[63:32]};
    return 64'h0;
  endfunction

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s stip actual=%0b expected=%0b t=%h cmp=%h", tag, act, exp, t, cmp_m);
    end
  endtask

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h addr=%h", tag, act, exp, addr);
    end
  endtask

  // called at a negedge with inputs set; checks, then advances one cycle
  task automatic cyc(input string tag);
    #1;
    chk1(tag, stip, stce ? ge_m : leg);
    chk64(tag, rdata, exp_rd(cmp_m, addr, split));
    @(posedge clk);
    ge_m = (t >= cmp_m);
    if (we) cmp_m = apply_wr(cmp_m, addr, split, wdata);
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [63:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc(tag);
    we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value and idle pending
    addr = 12'h14D; split = 1'b0;
    cyc("R1");
    cyc("R1");
    // R2: full-width write and read
    wr("R2", 12'h14D, 64'h0000_0000_0000_0100);
    cyc("R2");
    // R6: time reaches compare, output lags one cycle
    t = 64'h100;
    cyc("R6");
    cyc("R5");
    t = 64'hFF;
    cyc("R6");
    cyc("R5");
    // R5: unsigned compare across bit 63
    wr("R2", 12'h14D, 64'h8000_0000_0000_0000);
    t = 64'h7FFF_FFFF_FFFF_FFFF;
    cyc("R5");
    cyc("R5");
    t = 64'hFFFF_FFFF_FFFF_FFFF;
    cyc("R5");
    cyc("R5");
    // R6: compare write clears pending one cycle later
    t = 64'h10;
    wr("R6", 12'h14D, 64'h20);
    cyc("R6");
    wr("R6", 12'h14D, 64'h10);
    cyc("R6");
    cyc("R6");
    // R3: split halves
    split = 1'b1;
    wr("R3", 12'h14D, 64'hDEAD_BEEF_AAAA_5555);
    addr = 12'h15D; cyc("R3");
    addr = 12'h14D; cyc("R3");
    wr("R3", 12'h15D, 64'hCAFE_F00D_0000_0001);
    addr = 12'h14D; cyc("R3");
    addr = 12'h15D; cyc("R3");
    t = 64'h1_AAAA_5555;
    cyc("R3");
    cyc("R3");
    // R4: stray addresses
    split = 1'b0;
    wr("R4", 12'h15D, 64'h1234_5678_9ABC_DEF0);
    addr = 12'h15D; cyc("R4");
    wr("R4", 12'h300, 64'h0);
    addr = 12'h14D; cyc("R4");
    // R7: disabled, legacy bit passes straight through, writes still land
    stce = 1'b0; t = 64'h0;
    leg = 1'b1; cyc("R7");
    leg = 1'b0; cyc("R7");
    wr("R7", 12'h14D, 64'h5);
    leg = 1'b1; cyc("R7");
    // R9: comparator runs while disabled
    t = 64'h5; leg = 1'b0;
    cyc("R9");
    cyc("R9");
    stce = 1'b1;
    cyc("R9");
    // R8: legacy ignored while enabled
    wr("R8", 12'h14D, 64'hFFFF_0000_0000_0000);
    leg = 1'b1;
    cyc("R8");
    cyc("R8");
    leg = 1'b0;
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] base = cmp_m;
      case ($urandom_range(0, 3))
        0: t = base;
        1: t = base + 64'($urandom_range(0, 3)) - 64'd2;
        2: t = {$urandom, $urandom};
        default: t = t + 64'd1;
      endcase
      split = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: addr = 12'h15D;
        1: addr = 12'h0A5;
        default: addr = 12'h14D;
      endcase
      we = ($urandom_range(0, 3) == 0);
      wdata = ($urandom_range(0, 1) == 1) ? t + 64'($urandom_range(0, 2)) - 64'd1
                                          : {$urandom, $urandom};
      stce = ($urandom_range(0, 7) != 0);
      leg = $urandom_range(0, 1);
      cyc("R5/R6/R7/R8");
    end
    we = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule